// File: doc/BRIEF.md
# Serial Priority Interrupt Acknowledge Chain

This block models a row of interrupt-capable device cells that share one active-low request line to the processor and take turns on one vector bus. Each cell holds a pending flag from its device. The request line falls when any cell is pending. When the processor raises its acknowledge, the acknowledge enters the first cell and ripples down the row. A cell that is not pending passes the acknowledge to the next cell. A cell that is pending keeps the acknowledge and blocks it from every cell below. Position along the row is the only source of priority. No central encoder takes part.

The ripple through the cells is purely combinational. The vector of the claiming cell is captured into an output register on the clock edge where the acknowledge is high. If no cell claims on that edge, the register loads zero and the valid flag stays low. The number of cells, the vector width and each cell's vector are parameters.

Top module: `prio_ripple_ack`

## Requirements
- R1: `reqLineN` is 0 whenever at least one bit of `devReq` is 1.
- R2: `reqLineN` is 1 when every bit of `devReq` is 0.
- R3: While `ackIn` is 0, every bit of `prioOut` is 0.
- R4: With `ackIn` at 1, a cell whose priority input is 1 and whose `devReq` bit is 1 drives its `prioOut` bit to 0. Cell 0's priority input is `ackIn`. Cell i+1's priority input is `prioOut[i]`.
- R5: With `ackIn` at 1, a cell whose priority input is 1 and whose `devReq` bit is 0 drives its `prioOut` bit to 1. As a result, `prioOut[i]` is 1 exactly when `devReq[0..i]` are all 0.
- R6: At most one cell claims the acknowledge. The claiming cell is the lowest-indexed cell with its `devReq` bit set, and cell 0 has the highest priority.
- R7: After a rising clock edge where `ackIn` is 1 and some `devReq` bit is 1, `vecValid` is 1 and `dataBus` holds the winning cell's vector. That vector is slice i of `VEC_TABLE`; the defaults are 0x10, 0x24, 0x38 and 0x4C for cells 0 to 3.
- R8: After a rising edge where `ackIn` is 1 and no `devReq` bit is set, `dataBus` is 0 and `vecValid` is 0.
- R9: After a rising edge where `ackIn` is 0, `dataBus` is 0 and `vecValid` is 0, whatever `devReq` holds.
- R10: While reset is asserted and right after it is released, `dataBus` is 0 and `vecValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| devReq | input | NUM_DEV | Pending request of each cell; bit 0 is the cell nearest the processor |
| ackIn | input | 1 | Acknowledge from the processor into cell 0 |
| reqLineN | output | 1 | Shared request line, active low |
| prioOut | output | NUM_DEV | Priority output of each cell |
| dataBus | output | VEC_W | Registered vector of the claiming cell, zero if none |
| vecValid | output | 1 | Registered flag: a cell claimed the last acknowledge |

## Verification
The bench applies all sixteen request patterns while the acknowledge is high. A pattern with a single cell pending shows each vector reaching the bus. Patterns with several cells pending show that the lower index always wins, and each of them also checks the full `prioOut` ripple. The same patterns are then applied with the acknowledge low, which separates a cell that really blocks from one that only looks idle. The all-zero pattern with the acknowledge high tells an empty claim apart from a stale vector left in the register.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef struct packed {
    logic capture;
    logic clear;
  } ctlStrobe_t;
endpackage

// File: rtl/irqc_cell.sv
module irqc_cell (
  input  logic prioIn,
  input  logic pending,
  output logic prioOut,
  output logic claim
);
  // A pending cell keeps the acknowledge; an idle one forwards it.
  assign claim   = prioIn & pending;
  assign prioOut = prioIn & ~pending;
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic               ackIn,
  input  logic               anyClaim,
  output logic               reqLineN,
  output ctlStrobe_t         strobes
);
  // Negative-logic OR of all pending requests.
  assign reqLineN        = ~(|devReq);
  assign strobes.capture = ackIn & anyClaim;
  assign strobes.clear   = ~(ackIn & anyClaim);

  // R8: an idle request line can never lead to a capture
  a_r8_no_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reqLineN |-> !strobes.capture);
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int                         NUM_DEV   = 4,
  parameter int                         VEC_W     = 8,
  parameter logic [NUM_DEV*VEC_W-1:0]   VEC_TABLE = {8'h4C, 8'h38, 8'h24, 8'h10}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ackIn,
  input  logic [NUM_DEV-1:0] devReq,
  input  ctlStrobe_t         strobes,
  input  logic               reqLineN,
  output logic [NUM_DEV-1:0] prioOut,
  output logic               anyClaim,
  output logic [VEC_W-1:0]   dataBus,
  output logic               vecValid
);
  localparam int CHAIN_LEN = NUM_DEV + 1;

  logic [CHAIN_LEN-1:0] piVec;
  logic [NUM_DEV-1:0]   claim;
  logic [VEC_W-1:0]     muxVec;

  assign piVec[0] = ackIn;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cell
    irqc_cell u_cell (
      .prioIn (piVec[g]),
      .pending(devReq[g]),
      .prioOut(piVec[g+1]),
      .claim  (claim[g])
    );
  end

  assign prioOut  = piVec[CHAIN_LEN-1:1];
  assign anyClaim = |claim;

  // Shared bus modelled as an AND-OR mux; claim is at most one-hot.
  always_comb begin
    muxVec = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      muxVec = muxVec | ({VEC_W{claim[i]}} & VEC_TABLE[i*VEC_W +: VEC_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataBus  <= '0;
      vecValid <= 1'b0;
    end else if (strobes.capture) begin
      dataBus  <= muxVec;
      vecValid <= 1'b1;
    end else if (strobes.clear) begin
      dataBus  <= '0;
      vecValid <= 1'b0;
    end
  end

  // R6: never more than one claimant on the bus
  a_r6_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim));
  // R3: no acknowledge, nothing passes down the chain
  a_r3_blocked_chain: assert property (@(posedge clk) disable iff (!rst_n)
    !ackIn |-> (prioOut == '0));
  // R1: a claimant implies the shared line is pulled low
  a_r1_claim_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    anyClaim |-> !reqLineN);
  // R7: acknowledged request yields a valid vector next cycle
  a_r7_capture_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && (devReq != '0)) |=> vecValid);
  // R9: no acknowledge gives an empty bus next cycle
  a_r9_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !ackIn |=> (!vecValid && dataBus == '0));
endmodule

// File: rtl/prio_ripple_ack.sv
module prio_ripple_ack
  import irqc_pkg::*;
#(
  parameter int                       NUM_DEV   = 4,
  parameter int                       VEC_W     = 8,
  parameter logic [NUM_DEV*VEC_W-1:0] VEC_TABLE = {8'h4C, 8'h38, 8'h24, 8'h10}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic               ackIn,
  output logic               reqLineN,
  output logic [NUM_DEV-1:0] prioOut,
  output logic [VEC_W-1:0]   dataBus,
  output logic               vecValid
);
  ctlStrobe_t strobes;
  logic       anyClaim;

  irqc_ctrl #(.NUM_DEV(NUM_DEV)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .devReq  (devReq),
    .ackIn   (ackIn),
    .anyClaim(anyClaim),
    .reqLineN(reqLineN),
    .strobes (strobes)
  );

  irqc_datapath #(
    .NUM_DEV  (NUM_DEV),
    .VEC_W    (VEC_W),
    .VEC_TABLE(VEC_TABLE)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ackIn   (ackIn),
    .devReq  (devReq),
    .strobes (strobes),
    .reqLineN(reqLineN),
    .prioOut (prioOut),
    .anyClaim(anyClaim),
    .dataBus (dataBus),
    .vecValid(vecValid)
  );
endmodule

// File: tb/prio_ripple_ack_bench.sv
module prio_ripple_ack_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] devReq = '0;
  logic       ackIn = 1'b0;
  logic       reqLineN;
  logic [3:0] prioOut;
  logic [7:0] dataBus;
  logic       vecValid;

  int checks = 0;
  int errors = 0;
  logic [8:0] expQ[$];
  string      tagQ[$];
  bit         done = 0;

  always #10 clk = ~clk;

  prio_ripple_ack u_prio_ripple_ack (
    .clk(clk), .rst_n(rst_n), .devReq(devReq), .ackIn(ackIn),
    .reqLineN(reqLineN), .prioOut(prioOut), .dataBus(dataBus), .vecValid(vecValid)
  );

  function automatic logic [7:0] vecOf(int idx);
    case (idx)
      0: return 8'h10;
      1: return 8'h24;
      2: return 8'h38;
      default: return 8'h4C;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: applies one pattern, checks the ripple, queues the registered result.
  task automatic drive(logic [3:0] req, logic ack);
    logic [3:0] expPo;
    logic [7:0] expBus;
    logic       expVal;
    logic       passing;
    int         win;
    @(negedge clk);
    devReq = req;
    ackIn  = ack;
    #1;
    check(req != 0 ? "R1 reqLineN low" : "R2 reqLineN high", reqLineN, (req == 0));
    passing = ack;
    win = -1;
    for (int i = 0; i < 4; i++) begin
      if (passing && req[i] && win < 0) win = i;
      passing = passing & ~req[i];
      expPo[i] = passing;
    end
    check(ack ? "R4/R5 prioOut ripple" : "R3 prioOut blocked", prioOut, expPo);
    expVal = (win >= 0);
    expBus = expVal ? vecOf(win) : 8'h00;
    expQ.push_back({expVal, expBus});
    tagQ.push_back(!ack ? "R9 no ack" : (expVal ? "R6/R7 winner vector" : "R8 empty ack"));
  endtask

  // Monitor: pops expectations after each capture edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        logic [8:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {vecValid, dataBus}, e);
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 bus in reset", {vecValid, dataBus}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 bus after reset", {vecValid, dataBus}, 9'h000);
    for (int p = 0; p < 16; p++) drive(p[3:0], 1'b1);
    for (int p = 15; p >= 0; p--) drive(p[3:0], 1'b0);
    // Alternate to catch stale vectors between acknowledges.
    drive(4'b1000, 1'b1);
    drive(4'b0000, 1'b1);
    drive(4'b0110, 1'b1);
    drive(4'b0110, 1'b0);
    drive(4'b1001, 1'b1);
    @(negedge clk);
    devReq = '0;
    ackIn  = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule